// File: doc/BRIEF.md
# Clock Register Access Port with Two Byte Banks

This block sits between a narrow host I/O bus and a real-time clock. The host reaches two banks of 128 bytes each through pairs of ports. One port of a pair holds a byte index and the other moves data to or from the byte that index selects. The standard bank reaches the clock registers at its low indices: ten time and date bytes, followed by four control registers. Its remaining indices hold general-purpose RAM. The extended bank is plain storage throughout.

Clock registers are not stored here. Reads and writes to them go out on a register-port interface to the timekeeping engine, and their read data comes back combinationally. The block drops host writes to time and date bytes while the engine reports an update in progress. It drops writes to the two read-only control registers. When the clock function is switched off, the clock registers are fenced off and the extended bank still works. When the extended bank is disabled, its port pair behaves as a second copy of the standard pair.

Top module: `rtc_host_port`

## Requirements
- R1: After reset both index registers are 0 and every RAM byte of both banks reads 00h.
- R2: A write to offset 0 loads the standard index from bits 6:0 of the written byte and ignores bit 7. A read of offset 0 returns the index with bit 7 clear.
- R3: With ext_en=1, a write to offset 2 loads the extended index in the same way as R2. Offset 3 then reads and writes extended byte [index], and offset 2 reads back the extended index.
- R4: With ext_en=0, offsets 2 and 3 act exactly like offsets 0 and 1, and the extended index and extended bytes stay unchanged.
- R5: Offset 1 at standard indices 0Eh to 7Fh reads and writes general-purpose RAM. A write becomes readable from the next cycle on.
- R6: Offset 1 at standard indices 00h to 0Dh drives tk_addr with the low 4 index bits. While rtc_en=1 it returns tk_rdata in the same cycle.
- R7: A write at offset 1 to standard indices 00h to 0Bh raises tk_wr for that one cycle, with tk_addr equal to the index and tk_wdata equal to the written byte. This holds while rtc_en=1 and the R8/R9 conditions do not apply.
- R8: Writes to indices 0Ch and 0Dh (read-only control registers) never raise tk_wr.
- R9: While tk_uip=1, writes to indices 00h to 09h do not raise tk_wr. Writes to 0Ah and 0Bh still do.
- R10: While rtc_en=0, tk_wr stays low and reads of standard indices 00h to 0Dh return FFh. General-purpose RAM and the extended bank work unchanged.
- R11: io_rdata is 00h in any cycle without io_sel and io_rd both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_sel | input | 1 | Host access to this block in this cycle |
| io_wr | input | 1 | Host write strobe |
| io_rd | input | 1 | Host read strobe |
| io_off | input | 2 | Port offset: 0/1 standard index/data, 2/3 extended index/data |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Host read data, combinational |
| ext_en | input | 1 | Extended bank enabled; when low, offsets 2/3 alias 0/1 |
| rtc_en | input | 1 | Clock function enabled |
| tk_uip | input | 1 | Timekeeping engine is updating the time bytes |
| tk_rdata | input | 8 | Read data from the timekeeping engine for tk_addr |
| tk_wr | output | 1 | Write strobe to the timekeeping engine |
| tk_addr | output | 4 | Clock register number |
| tk_wdata | output | 8 | Write data to the timekeeping engine |

## Verification
Two things can land in one cycle. A data-port write to a time byte can coincide with tk_uip, so the update lock and the write routing meet. A write to offset 2 or 3 can coincide with ext_en low, so the alias and the extended index register meet. The bench raises tk_uip during writes that walk every clock index, and flips ext_en between back-to-back writes on offset 2 and 3. In every cycle, a behavioural model of indices and byte arrays gives the expected tk_wr, tk_addr, tk_wdata and io_rdata.

// File: rtl/rtc_port_pkg.sv
package rtc_port_pkg;

  localparam int unsigned TIME_BYTES = 10;
  localparam int unsigned CTRL_BYTES = 4;
  localparam int unsigned USER_BASE  = TIME_BYTES + CTRL_BYTES;
  localparam int unsigned RO_FIRST   = TIME_BYTES + 2;
  localparam int unsigned CLK_AW     = $clog2(USER_BASE);

  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_STD_IDX,
    SRC_EXT_IDX,
    SRC_STD_RAM,
    SRC_EXT_RAM,
    SRC_CLOCK,
    SRC_FENCED
  } rd_src_e;

  typedef struct packed {
    logic    ld_std;
    logic    ld_ext;
    logic    std_we;
    logic    ext_we;
    logic    tk_we;
    logic    lock_drop;
    rd_src_e src;
  } dec_t;

  function automatic logic is_clock_reg(input int unsigned idx);
    return idx < USER_BASE;
  endfunction

  function automatic logic is_time_byte(input int unsigned idx);
    return idx < TIME_BYTES;
  endfunction

  function automatic logic is_read_only(input int unsigned idx);
    return (idx >= RO_FIRST) && (idx < USER_BASE);
  endfunction

endpackage

// File: rtl/rtc_port_decode.sv
module rtc_port_decode
  import rtc_port_pkg::*;
#(
  parameter int unsigned IDX_W = 7
) (
  input  logic             io_sel,
  input  logic             io_wr,
  input  logic             io_rd,
  input  logic [1:0]       io_off,
  input  logic             ext_en,
  input  logic             rtc_en,
  input  logic             tk_uip,
  input  logic [IDX_W-1:0] std_idx,
  output dec_t             dec
);

  logic [1:0] eff_off;
  logic       wr, rd, clock_hit;

  // Aliasing: with the extended bank off, bit 1 of the offset is dropped.
  assign eff_off   = ext_en ? io_off : {1'b0, io_off[0]};
  assign wr        = io_sel && io_wr;
  assign rd        = io_sel && io_rd;
  assign clock_hit = is_clock_reg(int'(std_idx));

  always_comb begin
    dec           = '0;
    dec.src       = SRC_NONE;
    dec.ld_std    = wr && (eff_off == 2'd0);
    dec.ld_ext    = wr && (eff_off == 2'd2);
    dec.ext_we    = wr && (eff_off == 2'd3);
    dec.std_we    = wr && (eff_off == 2'd1) && !clock_hit;
    dec.lock_drop = wr && (eff_off == 2'd1) && clock_hit &&
                    tk_uip && is_time_byte(int'(std_idx));
    dec.tk_we     = wr && (eff_off == 2'd1) && clock_hit && rtc_en &&
                    !is_read_only(int'(std_idx)) && !dec.lock_drop;
    if (rd) begin
      unique case (eff_off)
        2'd0: dec.src = SRC_STD_IDX;
        2'd2: dec.src = SRC_EXT_IDX;
        2'd3: dec.src = SRC_EXT_RAM;
        default: dec.src = !clock_hit ? SRC_STD_RAM :
                           (rtc_en ? SRC_CLOCK : SRC_FENCED);
      endcase
    end
  end

endmodule

// File: rtl/rtc_port_ram.sv
module rtc_port_ram #(
  parameter int unsigned AW = 7,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/rtc_host_port.sv
module rtc_host_port
  import rtc_port_pkg::*;
#(
  parameter int unsigned IDX_W = 7,
  parameter int unsigned DW    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_sel,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [1:0]        io_off,
  input  logic [DW-1:0]     io_wdata,
  output logic [DW-1:0]     io_rdata,
  input  logic              ext_en,
  input  logic              rtc_en,
  input  logic              tk_uip,
  input  logic [DW-1:0]     tk_rdata,
  output logic              tk_wr,
  output logic [CLK_AW-1:0] tk_addr,
  output logic [DW-1:0]     tk_wdata
);

  localparam int unsigned NBANK = 2;

  logic [IDX_W-1:0] std_idx, ext_idx;
  dec_t             dec;
  logic [DW-1:0]    bank_rd [NBANK];
  logic [IDX_W-1:0] bank_ad [NBANK];
  logic             bank_we [NBANK];

  rtc_port_decode #(.IDX_W(IDX_W)) u_dec (
    .io_sel (io_sel),
    .io_wr  (io_wr),
    .io_rd  (io_rd),
    .io_off (io_off),
    .ext_en (ext_en),
    .rtc_en (rtc_en),
    .tk_uip (tk_uip),
    .std_idx(std_idx),
    .dec    (dec)
  );

  // Index registers; the top bit of the written byte is discarded.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      std_idx <= '0;
      ext_idx <= '0;
    end else begin
      if (dec.ld_std) std_idx <= io_wdata[IDX_W-1:0];
      if (dec.ld_ext) ext_idx <= io_wdata[IDX_W-1:0];
    end
  end

  assign bank_ad[0] = std_idx;
  assign bank_ad[1] = ext_idx;
  assign bank_we[0] = dec.std_we;
  assign bank_we[1] = dec.ext_we;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    rtc_port_ram #(.AW(IDX_W), .DW(DW)) u_ram (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (bank_we[b]),
      .addr (bank_ad[b]),
      .wdata(io_wdata),
      .rdata(bank_rd[b])
    );
  end

  assign tk_wr    = dec.tk_we;
  assign tk_addr  = std_idx[CLK_AW-1:0];
  assign tk_wdata = io_wdata;

  always_comb begin
    unique case (dec.src)
      SRC_STD_IDX: io_rdata = DW'(std_idx);
      SRC_EXT_IDX: io_rdata = DW'(ext_idx);
      SRC_STD_RAM: io_rdata = bank_rd[0];
      SRC_EXT_RAM: io_rdata = bank_rd[1];
      SRC_CLOCK:   io_rdata = tk_rdata;
      SRC_FENCED:  io_rdata = '1;
      default:     io_rdata = '0;
    endcase
  end

  // Guards beside the logic they watch.
  assert_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tk_wr && tk_uip) |-> (int'(tk_addr) >= TIME_BYTES));

  assert_ro_ctrl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tk_wr |-> (int'(tk_addr) < RO_FIRST));

  assert_fence_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rtc_en |-> !tk_wr);

  assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_sel && io_rd) |-> (io_rdata == '0));

  assert_idx_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_sel && io_wr && io_off == 2'd0) |=> (std_idx == $past(io_wdata[IDX_W-1:0])));

  assert_alias_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_sel && io_wr && !ext_en) |=> ($stable(ext_idx) && $stable(bank_rd[1])));

  assert_user_ram_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dec.std_we |=> (bank_rd[0] == $past(io_wdata)));

endmodule

// File: tb/rtc_host_port_test.sv
module rtc_host_port_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       io_sel = 0, io_wr = 0, io_rd = 0;
  logic [1:0] io_off = 0;
  logic [7:0] io_wdata = 0;
  logic [7:0] io_rdata;
  logic       ext_en = 1, rtc_en = 1, tk_uip = 0;
  logic [7:0] tk_rdata;
  logic       tk_wr;
  logic [3:0] tk_addr;
  logic [7:0] tk_wdata;

  int total = 0, bad = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  // Engine stub: each clock register answers with A in the high nibble.
  assign tk_rdata = {4'hA, tk_addr};

  rtc_host_port uut (.*);

  // Reference model.
  int m_si = 0, m_xi = 0;
  int m_std [128];
  int m_ext [128];

  function automatic int eoff();
    return ext_en ? int'(io_off) : int'(io_off) % 2;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_si = 0; m_xi = 0;
      for (int i = 0; i < 128; i++) begin m_std[i] = 0; m_ext[i] = 0; end
    end else if (io_sel && io_wr) begin
      case (eoff())
        0: m_si = io_wdata % 128;
        2: m_xi = io_wdata % 128;
        3: m_ext[m_xi] = io_wdata;
        default: if (m_si >= 14) m_std[m_si] = io_wdata;
      endcase
    end
  end

  function automatic int exp_rdata();
    if (!(io_sel && io_rd)) return 0;
    case (eoff())
      0: return m_si;
      2: return m_xi;
      3: return m_ext[m_xi];
      default: begin
        if (m_si >= 14) return m_std[m_si];
        return rtc_en ? (160 + m_si) : 255;
      end
    endcase
  endfunction

  function automatic bit exp_tkwr();
    if (!(io_sel && io_wr) || eoff() != 1 || m_si >= 14 || !rtc_en) return 0;
    if (m_si == 12 || m_si == 13) return 0;
    if (tk_uip && m_si < 10) return 0;
    return 1;
  endfunction

  task automatic chk(input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s got=%0h exp=%0h", tag, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      chk("io_rdata", int'(io_rdata), exp_rdata());
      chk("tk_wr", int'(tk_wr), int'(exp_tkwr()));
      if (exp_tkwr()) begin
        chk("tk_addr", int'(tk_addr), m_si % 16);
        chk("tk_wdata", int'(tk_wdata), int'(io_wdata));
      end
    end
  end

  task automatic cyc(input bit w, input bit r, input int off, input int d);
    @(negedge clk);
    io_sel = w | r; io_wr = w; io_rd = r;
    io_off = 2'(off); io_wdata = 8'(d);
  endtask

  task automatic wr(input int off, input int d); cyc(1, 0, off, d); endtask
  task automatic rd(input int off); cyc(0, 1, off, 0); endtask
  task automatic idle(); cyc(0, 0, 0, 0); endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset values
    tag = "R1";
    rd(0); rd(2); rd(3); wr(0, 8'h40); rd(1); idle();
    // R2: bit 7 of index ignored
    tag = "R2";
    wr(0, 8'h9F); rd(0); rd(1); wr(0, 8'hFF); rd(0);
    // R5: user RAM edges and middle
    tag = "R5";
    foreach (m_std[k]) ; // no-op keeps loop style uniform
    for (int i = 0; i < 3; i++) begin
      int ix = (i == 0) ? 14 : (i == 1) ? 127 : 64;
      wr(0, ix); wr(1, 8'h30 + i); rd(1);
    end
    wr(0, 14); rd(1); wr(0, 127); rd(1);
    // R3: extended bank enabled
    tag = "R3";
    ext_en = 1;
    wr(2, 8'h85); wr(3, 8'h5A); rd(3); rd(2); wr(2, 8'h7F); wr(3, 8'hC3); rd(3);
    wr(2, 5); rd(3); wr(0, 5); rd(1);
    // R4: alias; flip ext_en between writes
    tag = "R4";
    ext_en = 0;
    wr(2, 8'h20); wr(3, 8'h77); rd(3); rd(1); rd(2);
    ext_en = 1; rd(2); wr(2, 8'h21); ext_en = 0; wr(3, 8'h66); rd(1);
    ext_en = 1; rd(3); wr(2, 8'h20); rd(3); idle();
    // R6: reads of all clock registers
    tag = "R6";
    for (int i = 0; i < 14; i++) begin wr(0, i); rd(1); end
    // R7 / R8: writes with no update in progress
    tag = "R7";
    for (int i = 0; i < 14; i++) begin
      tag = (i >= 12) ? "R8" : "R7";
      wr(0, i); wr(1, 8'h10 + i);
    end
    // R9: writes during update
    tag = "R9";
    tk_uip = 1;
    for (int i = 0; i < 14; i++) begin wr(0, i); wr(1, 8'hE0 + i); rd(1); end
    tk_uip = 0;
    wr(0, 9); tk_uip = 1; wr(1, 8'h99); tk_uip = 0; wr(1, 8'h98);
    // R10: clock disabled
    tag = "R10";
    rtc_en = 0;
    for (int i = 0; i < 14; i++) begin wr(0, i); wr(1, 8'h55); rd(1); end
    wr(0, 8'h50); wr(1, 8'hAB); rd(1);
    wr(2, 8'h11); wr(3, 8'hBE); rd(3);
    rtc_en = 1;
    // R11: no read strobe means zero data
    tag = "R11";
    wr(2, 8'h11); cyc(1, 0, 3, 8'hEE); idle(); cyc(0, 0, 3, 0); rd(3);
    idle(); idle();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule